// File: doc/BRIEF.md
# Page-Mode Static Memory Read Sequencer

This block performs reads from an external asynchronous 8-bit memory that supports page mode. An internal master raises a request and supplies a chip-select index and a byte address. The block drives the address bus, one active-low chip select and an active-low read strobe. It captures the byte on the data pins and returns it with a one-cycle ready pulse.

The block keeps a tag for the page it opened last. The tag holds the chip-select index and the address bits above the in-page offset. A read whose tag matches the open page is served with the short in-page time, whatever its offset. Any other read opens a new page with the long time. The chip select stays low across back-to-back reads. A cycle in which the block is free and no request is present releases every chip select and forgets the open page. An access through another chip select, such as a different device, also breaks the page.

Both access times are run-time inputs counted in clock cycles. A value of zero acts as one. The page size is a power-of-two parameter. With the default of 8 bytes, address bits [2:0] form the in-page offset and bits from 3 upward form the page address.

Top module: `pgmem_rd_seq`

## Requirements
- R1: After reset, every bit of `mem_cs_n` is 1, `mem_rd_n` is 1 and `ready` is 0.
- R2: A read accepted when no page is open holds `mem_rd_n` low for exactly `long_cyc` consecutive cycles.
- R3: A read whose chip-select index and address bits above the offset (bits [ADDR_W-1:3] for 8-byte pages) match the preceding read holds `mem_rd_n` low for exactly `short_cyc` cycles. This applies to any offset, sequential or not.
- R4: A read whose address bits above the offset differ from the preceding read uses `long_cyc`.
- R5: A read with a chip-select index different from the preceding read uses `long_cyc`. A read that returns to an earlier device after an access to another device also uses `long_cyc`.
- R6: When the block is free and `req` is low at a clock edge, all chip selects go high. The next read then uses `long_cyc`.
- R7: While a read is in progress or its ready cycle is shown, exactly one bit of `mem_cs_n` is low: bit `req_cs`. Between back-to-back reads that bit stays low.
- R8: `rdata` equals `mem_data` as sampled on the last low cycle of the strobe. `ready` is high for exactly one cycle, directly after that strobe ends.
- R9: An access time of 0 on `long_cyc` or `short_cyc` is treated as 1 cycle.
- R10: `mem_addr` equals the requested byte address for the whole strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, held with its operands until `ready` |
| req_cs | input | CS_W (2) | Chip-select index of the request |
| req_addr | input | ADDR_W (16) | Byte address of the request |
| long_cyc | input | CNT_W (8) | Strobe length in cycles when a new page is opened |
| short_cyc | input | CNT_W (8) | Strobe length in cycles for an in-page hit |
| ready | output | 1 | One-cycle pulse when `rdata` is valid |
| rdata | output | 8 | Byte read |
| mem_addr | output | ADDR_W (16) | External address bus |
| mem_cs_n | output | NUM_CS (4) | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_data | input | 8 | External data bus |

## Verification
A stale or wrongly cleared page tag appears on the very next read as a strobe of the wrong length. The bench counts the length of every strobe, so such an error is caught within one access. Each sequence is built to separate the cases: in-page offsets out of order, a crossing of the page boundary by one byte, interleaved devices and a single idle cycle. A wrong chip-select or address register appears on the pins during the strobe itself. The memory model returns a byte that depends on both the address and the selected device, so the same fault also shows up in `rdata` in the same access.

// File: rtl/pgmem_rd_seq.sv
module pgmem_rd_seq #(
  parameter int ADDR_W     = 16,
  parameter int NUM_CS     = 4,
  parameter int PAGE_BYTES = 8,
  parameter int CNT_W      = 8,
  localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int TAG_W     = CS_W + ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  long_cyc,
  input  logic [CNT_W-1:0]  short_cyc,
  output logic              ready,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_rd_n,
  input  logic [7:0]        mem_data
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_HOLD} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [TAG_W-1:0]  tag_q;
  logic              tag_ok;
  logic [ADDR_W-1:0] addr_q;
  logic [CS_W-1:0]   cs_q;
  logic [7:0]        rdata_q;
  logic              ready_q;

  logic [TAG_W-1:0]  req_tag;
  logic              hit;
  logic [CNT_W-1:0]  want;
  logic [CNT_W-1:0]  load;

  assign req_tag = {req_cs, req_addr[ADDR_W-1:OFF_W]};
  assign hit     = tag_ok && (req_tag == tag_q);
  assign want    = hit ? short_cyc : long_cyc;
  assign load    = (want == '0) ? CNT_W'(1) : want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      tag_q   <= '0;
      tag_ok  <= 1'b0;
      addr_q  <= '0;
      cs_q    <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      case (st)
        S_RD: begin
          if (cnt == CNT_W'(1)) begin
            rdata_q <= mem_data;
            ready_q <= 1'b1;
            st      <= S_HOLD;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          if (req) begin
            st     <= S_RD;
            cnt    <= load;
            tag_q  <= req_tag;
            tag_ok <= 1'b1;
            addr_q <= req_addr;
            cs_q   <= req_cs;
          end else begin
            st     <= S_IDLE;
            tag_ok <= 1'b0;
          end
        end
      endcase
    end
  end

  assign mem_rd_n = (st != S_RD);
  assign mem_cs_n = (st == S_IDLE) ? '1 : ~(NUM_CS'(1) << cs_q);
  assign mem_addr = addr_q;
  assign rdata    = rdata_q;
  assign ready    = ready_q;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R7
  AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> ($countones(~mem_cs_n) == 1)); // R7
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R8
  AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (mem_rd_n && $past(!mem_rd_n))); // R8
  AST_IDLE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !req) |=> (&mem_cs_n)); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && $past(!mem_rd_n)) |-> $stable(mem_addr)); // R10

endmodule

// File: tb/pgmem_rd_seq_test.sv
module pgmem_rd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  req_cs = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  long_cyc = 8'd5;
  logic [7:0]  short_cyc = 8'd2;
  logic        ready;
  logic [7:0]  rdata;
  logic [15:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_rd_n;
  logic [7:0]  mem_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign mem_data = mem_addr[7:0] ^ {4'h5, ~mem_cs_n};

  pgmem_rd_seq uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_cs(req_cs), .req_addr(req_addr),
    .long_cyc(long_cyc), .short_cyc(short_cyc), .ready(ready), .rdata(rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_data(mem_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; leaves req high at the negedge where ready is seen.
  task automatic do_read(input logic [1:0] cs, input logic [15:0] addr,
                         input int exp_len, input string tag);
    int n = 0;
    int guard = 0;
    bit cs_bad = 1'b0;
    bit addr_bad = 1'b0;
    logic [3:0] exp_cs = ~(4'b0001 << cs);
    req = 1'b1; req_cs = cs; req_addr = addr;
    forever begin
      @(negedge clk);
      guard++;
      if (!mem_rd_n) begin
        n++;
        if (mem_cs_n !== exp_cs) cs_bad = 1'b1;
        if (mem_addr !== addr) addr_bad = 1'b1;
      end
      if (ready || guard > 300) break;
    end
    chk(n == exp_len, {tag, " strobe length"}, n, exp_len);
    chk(!cs_bad && mem_cs_n === exp_cs, "R7 chip select during access", int'(mem_cs_n), int'(exp_cs));
    chk(!addr_bad, "R10 address during strobe", int'(mem_addr), int'(addr));
    chk(rdata === (addr[7:0] ^ {4'h5, ~exp_cs}), "R8 read data", int'(rdata),
        int'(addr[7:0] ^ {4'h5, ~exp_cs}));
  endtask

  task automatic go_idle();
    req = 1'b0;
    @(negedge clk);
    chk(mem_cs_n === 4'hF, "R6 chip selects released on idle", int'(mem_cs_n), 15);
    chk(ready === 1'b0, "R8 ready lasts one cycle", int'(ready), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_cs_n === 4'hF, "R1 reset chip selects", int'(mem_cs_n), 15);
    chk(mem_rd_n === 1'b1, "R1 reset strobe", int'(mem_rd_n), 1);
    chk(ready === 1'b0, "R1 reset ready", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n === 4'hF && mem_rd_n === 1'b1, "R1 idle after reset", int'(mem_cs_n), 15);
  endtask

  task automatic t_page_hits();
    do_read(2'd0, 16'h0101, 5, "R2 first access");
    do_read(2'd0, 16'h0103, 2, "R3 hit offset 3");
    do_read(2'd0, 16'h0107, 2, "R3 hit offset 7");
    do_read(2'd0, 16'h0100, 2, "R3 hit offset 0");
    go_idle();
  endtask

  task automatic t_page_change();
    do_read(2'd0, 16'h0107, 5, "R2 open page");
    do_read(2'd0, 16'h0108, 5, "R4 next page");
    do_read(2'd0, 16'h0109, 2, "R3 hit in new page");
    do_read(2'd0, 16'h8109, 5, "R4 top bit differs");
    go_idle();
  endtask

  task automatic t_cs_change();
    do_read(2'd0, 16'h0200, 5, "R2 device 0");
    do_read(2'd1, 16'h0201, 5, "R5 other device");
    do_read(2'd0, 16'h0202, 5, "R5 back to device 0");
    do_read(2'd0, 16'h0203, 2, "R3 device 0 hit");
    go_idle();
  endtask

  task automatic t_idle_break();
    do_read(2'd2, 16'h0300, 5, "R2 device 2");
    go_idle();
    do_read(2'd2, 16'h0301, 5, "R6 after idle cycle");
    go_idle();
  endtask

  task automatic t_zero_time();
    short_cyc = 8'd0;
    do_read(2'd3, 16'h0400, 5, "R2 device 3");
    do_read(2'd3, 16'h0406, 1, "R9 short zero");
    go_idle();
    long_cyc = 8'd0;
    short_cyc = 8'd3;
    do_read(2'd3, 16'h0405, 1, "R9 long zero");
    do_read(2'd3, 16'h0402, 3, "R3 short three");
    go_idle();
    long_cyc = 8'd5;
    short_cyc = 8'd2;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_page_hits();
    t_page_change();
    t_cs_change();
    t_idle_break();
    t_zero_time();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule